// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes that software picks up through a small register-style read port. It watches the line for a falling edge, confirms the start bit at its midpoint, then takes each data bit, an optional parity bit and the first stop bit from a 16x oversampling tick. Each bit value is the majority of three samples around the bit centre. The line passes through a two-flop synchronizer and idles high.

Completed frames go into a two-entry queue. Each entry carries its byte together with its own frame-error, overrun and parity-error flags. The status outputs always describe the entry at the head of the queue, so software reads status first and then data. Reading data pops the entry. A frame that arrives while the queue is full waits in a holding stage. A further start bit in that state loses a frame and raises an overrun indication. That indication is attached to the next frame moved into the queue. A level interrupt follows the receive-ready condition when it is enabled.

Top module: `uart_rx_buffered`

## Requirements
- R1: `rx_ready` is 1 whenever the queue holds at least one unread frame, and 0 when it is empty. Without a read it stays 1.
- R2: Driving `rx_en` low empties the queue and the holding stage and clears any pending overrun, so `rx_ready` is 0 on the next cycle.
- R3: `irq` equals `rx_ready AND int_en` as a level. No error flag drives `irq`.
- R4: `err_frame`, `err_overrun`, `err_parity` and `rx_dout` show the head entry, and all are 0 when the queue is empty. A one-cycle `rd_data` pulse pops the head.
- R5: `err_frame` is 1 when the first stop bit is sampled as 0, and 0 when it is sampled as 1. Bits after the first stop bit play no part in the frame.
- R6: `par_mode[1]`=1 enables a parity bit after the data. `par_mode[0]`=1 selects odd parity and 0 selects even parity. With `par_mode[1]`=0 no parity bit is expected and `err_parity` stays 0.
- R7: `dbits_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data arrives least significant bit first. Unused upper bits of `rx_dout` read 0.
- R8: The queue holds two frames and a third frame waits in the holding stage. If a start bit is confirmed in that state, the held frame is replaced by the new one. The next frame moved into the queue carries `err_overrun`=1. The frame after it carries 0.
- R9: A low pulse on the line that is high at the start-bit midpoint is discarded and produces no frame.
- R10: A `rd_data` pulse while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line input, idle high |
| rx_en | input | 1 | Receiver enable, low flushes |
| int_en | input | 1 | Receive interrupt enable |
| par_mode | input | 2 | Bit 1 parity enable, bit 0 odd parity |
| dbits_sel | input | 2 | Data bits minus five |
| rd_data | input | 1 | Read strobe for the data word (pops) |
| rx_ready | output | 1 | Unread frame present |
| err_frame | output | 1 | Head frame had a bad stop bit |
| err_overrun | output | 1 | Frames lost before the head frame |
| err_parity | output | 1 | Head frame failed the parity check |
| rx_dout | output | 8 | Head frame data |
| irq | output | 1 | Receive interrupt level |

## Verification
The bench fills the queue and the holding stage, then sends a fourth frame. It checks that the overrun flag lands on the replacement frame and not on either queued frame. A design that flagged too early or attached the flag to the head entry would show it on the wrong read. A design that held the flag would show it on the frame after. Other tests send a bad stop bit followed by an idle line, which must not become a false start. A short glitch must leave the queue empty. A read on an empty queue must not corrupt the count. Random frames mix all four widths and both parity senses with corrupted parity and stop bits, so flags paired with the wrong frame show up as mismatches.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int RX_DW = 8;

   typedef struct packed {
      logic [RX_DW-1:0] data;
      logic             fe;
      logic             dor;
      logic             pe;
   } rx_entry_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("uart_rx_sync needs at least two stages");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_bitengine.sv
module uart_rx_bitengine
   import uart_rx_pkg::*;
#(
   parameter int OSR      = 16,
   parameter int MIN_BITS = 5,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic             rx,
   input  logic [1:0]       par_mode,
   input  logic [SEL_W-1:0] dbits_sel,
   output logic             start_ok,
   output logic             done,
   output logic [RX_DW-1:0] data,
   output logic             fe,
   output logic             pe
);
   localparam int CW       = $clog2(OSR);
   localparam int MAX_BITS = MIN_BITS + (1 << SEL_W) - 1;
   localparam int BW       = $clog2(MAX_BITS);
   localparam int MID      = OSR / 2;

   generate
      if (OSR < 8 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 8");
      end
      if (MAX_BITS > RX_DW) begin : g_bad_bits
         $error("data width selection exceeds the data word");
      end
   endgenerate

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [BW-1:0]    bidx;
   logic             s_a, s_b, pbit;
   logic             vote;
   logic [BW-1:0]    last_idx;

   assign vote     = (s_a & s_b) | (s_a & rx) | (s_b & rx);
   assign last_idx = BW'(MIN_BITS - 1) + BW'(dbits_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; bidx <= '0;
         s_a <= 1'b1; s_b <= 1'b1; pbit <= 1'b0;
         start_ok <= 1'b0; done <= 1'b0;
         data <= '0; fe <= 1'b0; pe <= 1'b0;
      end else if (clear) begin
         state <= ST_IDLE; cnt <= '0;
         start_ok <= 1'b0; done <= 1'b0;
      end else begin
         start_ok <= 1'b0;
         done     <= 1'b0;
         if (tick) begin
            if (state == ST_IDLE) begin
               if (!rx) begin
                  state <= ST_START;
                  cnt   <= CW'(1);
               end
            end else begin
               cnt <= cnt + CW'(1);
               if (cnt == CW'(MID - 1)) s_a <= rx;
               if (cnt == CW'(MID))     s_b <= rx;
               if (cnt == CW'(MID + 1)) begin
                  case (state)
                     ST_START: begin
                        if (vote) state <= ST_IDLE;
                        else begin
                           start_ok <= 1'b1;
                           data     <= '0;
                           bidx     <= '0;
                        end
                     end
                     ST_DATA: data[bidx] <= vote;
                     ST_PAR:  pbit <= vote;
                     ST_STOP: begin
                        done  <= 1'b1;
                        fe    <= ~vote;
                        pe    <= par_mode[1] & (pbit ^ (^data) ^ par_mode[0]);
                        state <= ST_IDLE;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
               if (cnt == CW'(OSR - 1)) begin
                  case (state)
                     ST_START: state <= ST_DATA;
                     ST_DATA: begin
                        if (bidx == last_idx)
                           state <= par_mode[1] ? ST_PAR : ST_STOP;
                        else
                           bidx <= bidx + BW'(1);
                     end
                     ST_PAR:  state <= ST_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/uart_rx_fifo2.sv
module uart_rx_fifo2
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  rx_entry_t                  wentry,
   input  logic                       pop,
   output rx_entry_t                  head,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   rx_entry_t     mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rp];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                         mem[g] <= '0;
            else if (do_push && wp == AW'(g))   mem[g] <= wentry;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; level <= '0;
      end else if (flush) begin
         wp <= '0; rp <= '0; level <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered
   import uart_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int MIN_BITS    = 5,
   parameter int SEL_W       = 2,
   parameter int DEPTH       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             rxd,
   input  logic             rx_en,
   input  logic             int_en,
   input  logic [1:0]       par_mode,
   input  logic [SEL_W-1:0] dbits_sel,
   input  logic             rd_data,
   output logic             rx_ready,
   output logic             err_frame,
   output logic             err_overrun,
   output logic             err_parity,
   output logic [RX_DW-1:0] rx_dout,
   output logic             irq
);
   localparam int LW = $clog2(DEPTH + 1);

   logic             rx_s, flush;
   logic             eng_start, eng_done, eng_fe, eng_pe;
   logic [RX_DW-1:0] eng_data;
   rx_entry_t        head, wentry;
   logic [LW-1:0]    level;
   logic             q_full, q_empty;

   logic             pend_v, ovr_pend;
   logic [RX_DW-1:0] pend_data;
   logic             pend_fe, pend_pe;
   logic             push_pend, push_new, push;

   assign flush = ~rx_en;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s));

   uart_rx_bitengine #(.OSR(OSR), .MIN_BITS(MIN_BITS), .SEL_W(SEL_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .clear(flush), .tick(tick16), .rx(rx_s),
      .par_mode(par_mode), .dbits_sel(dbits_sel), .start_ok(eng_start),
      .done(eng_done), .data(eng_data), .fe(eng_fe), .pe(eng_pe));

   assign push_pend = pend_v & ~q_full;
   assign push_new  = eng_done & ~pend_v & ~q_full;
   assign push      = push_pend | push_new;

   always_comb begin
      if (push_pend) wentry = '{data: pend_data, fe: pend_fe, dor: ovr_pend, pe: pend_pe};
      else           wentry = '{data: eng_data,  fe: eng_fe,  dor: ovr_pend, pe: eng_pe};
   end

   uart_rx_fifo2 #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wentry(wentry),
      .pop(rd_data), .head(head), .level(level), .full(q_full), .empty(q_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0; ovr_pend <= 1'b0;
         pend_data <= '0; pend_fe <= 1'b0; pend_pe <= 1'b0;
      end else if (flush) begin
         pend_v <= 1'b0; ovr_pend <= 1'b0;
      end else begin
         ovr_pend <= (ovr_pend & ~push) | (eng_start & q_full & pend_v);
         if (eng_done && !push_new) begin
            pend_v    <= 1'b1;
            pend_data <= eng_data;
            pend_fe   <= eng_fe;
            pend_pe   <= eng_pe;
         end else if (push_pend) begin
            pend_v <= 1'b0;
         end
      end
   end

   assign rx_ready    = ~q_empty;
   assign err_frame   = rx_ready & head.fe;
   assign err_overrun = rx_ready & head.dor;
   assign err_parity  = rx_ready & head.pe;
   assign rx_dout     = rx_ready ? head.data : '0;
   assign irq         = rx_ready & int_en;
endmodule

// File: rtl/uart_rx_buffered_chk.sv
module uart_rx_buffered_chk #(
   parameter int DEPTH = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rx_en,
   input logic                       int_en,
   input logic                       rd_data,
   input logic                       rx_ready,
   input logic                       err_frame,
   input logic                       err_overrun,
   input logic                       err_parity,
   input logic                       irq,
   input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
   assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !rd_data && rx_en) |=> rx_ready);

   assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_ready);

   assert_no_irq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en && (err_frame || err_overrun || err_parity)) |-> !irq);

   assert_empty_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |-> !(err_frame || err_overrun || err_parity));

   assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind uart_rx_buffered uart_rx_buffered_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .int_en(int_en), .rd_data(rd_data),
   .rx_ready(rx_ready), .err_frame(err_frame), .err_overrun(err_overrun),
   .err_parity(err_parity), .irq(irq), .fifo_level(level));

// File: tb/tb_uart_rx_buffered.sv
module tb_uart_rx_buffered;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 32;

   logic       clk = 0, rst_n = 0, tick16 = 0, rxd = 1, rx_en = 1, int_en = 0, rd_data = 0;
   logic [1:0] par_mode = 0, dbits_sel = 0;
   logic       rx_ready, err_frame, err_overrun, err_parity, irq;
   logic [7:0] rx_dout;
   int         checks = 0, errors = 0;

   uart_rx_buffered dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
      .int_en(int_en), .par_mode(par_mode), .dbits_sel(dbits_sel), .rd_data(rd_data),
      .rx_ready(rx_ready), .err_frame(err_frame), .err_overrun(err_overrun),
      .err_parity(err_parity), .rx_dout(rx_dout), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick16 = ~tick16;
   end

   function automatic logic [7:0] mask_d(logic [7:0] d, logic [1:0] sel);
      return d & 8'((9'd1 << (5 + sel)) - 9'd1);
   endfunction

   function automatic logic par_of(logic [7:0] d, logic [1:0] sel, logic odd);
      return (^mask_d(d, sel)) ^ odd;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive_bit(logic v);
      rxd = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(logic [7:0] d, logic [1:0] sel, logic [1:0] pm, logic flip, logic stop_ok);
      dbits_sel = sel; par_mode = pm;
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < 5 + int'(sel); i++) drive_bit(d[i]);
      if (pm[1]) drive_bit(par_of(d, sel, pm[0]) ^ flip);
      drive_bit(stop_ok);
      drive_bit(1'b1);
   endtask

   task automatic read_chk(string tag, logic [7:0] d, logic fe, logic dor, logic pe);
      check({tag, " ready"}, rx_ready, 1);
      check({tag, " data"}, rx_dout, d);
      check({tag, " frame err"}, err_frame, fe);
      check({tag, " overrun"}, err_overrun, dor);
      check({tag, " parity err"}, err_parity, pe);
      rd_data = 1;
      @(negedge clk);
      rd_data = 0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);
      // reset state
      check("R1 reset ready", rx_ready, 0);
      check("R3 reset irq", irq, 0);
      check("R4 reset flags", {err_frame, err_overrun, err_parity}, 0);

      // basic 8-bit frame, interrupt level
      send(8'hA5, 2'd3, 2'b00, 0, 1);
      check("R1 ready after frame", rx_ready, 1);
      check("R3 irq masked", irq, 0);
      int_en = 1; #1;
      check("R3 irq level", irq, 1);
      repeat (5) @(negedge clk);
      check("R3 irq still high", irq, 1);
      read_chk("R7 8-bit", 8'hA5, 0, 0, 0);
      check("R1 empty after read", rx_ready, 0);
      check("R3 irq drops", irq, 0);
      int_en = 0;

      // bad stop bit, followed by idle line: no false frame
      send(8'h3C, 2'd3, 2'b00, 0, 0);
      check("R3 error gives no irq", irq, 0);
      read_chk("R5 bad stop", 8'h3C, 1, 0, 0);
      check("R5 no spurious frame", rx_ready, 0);

      // pop on empty is ignored
      rd_data = 1; @(negedge clk); rd_data = 0; @(negedge clk);
      check("R10 empty pop", rx_ready, 0);
      send(8'h5A, 2'd3, 2'b00, 0, 1);
      send(8'h0F, 2'd0, 2'b00, 0, 1);
      read_chk("R10 first after empty pop", 8'h5A, 0, 0, 0);
      read_chk("R7 5-bit", 8'h0F, 0, 0, 0);
      check("R10 queue empty again", rx_ready, 0);

      // glitch rejection
      rxd = 0; repeat (6) @(negedge clk); rxd = 1;
      repeat (BIT_CLKS * 12) @(negedge clk);
      check("R9 glitch", rx_ready, 0);

      // parity senses
      send(8'h37, 2'd2, 2'b10, 0, 1);
      read_chk("R6 even ok", 8'h37, 0, 0, 0);
      send(8'h37, 2'd2, 2'b11, 1, 1);
      read_chk("R6 odd bad", 8'h37, 0, 0, 1);

      // overrun: fill queue and holding stage, then a fourth frame
      send(8'h11, 2'd3, 2'b00, 0, 1);
      send(8'h22, 2'd3, 2'b00, 0, 1);
      send(8'h33, 2'd3, 2'b00, 0, 1);
      check("R8 head before overrun", err_overrun, 0);
      send(8'h44, 2'd3, 2'b00, 0, 1);
      read_chk("R8 first queued", 8'h11, 0, 0, 0);
      read_chk("R8 second queued", 8'h22, 0, 0, 0);
      read_chk("R8 replacement flagged", 8'h44, 0, 1, 0);
      check("R8 drained", rx_ready, 0);
      send(8'h55, 2'd3, 2'b00, 0, 1);
      read_chk("R8 overrun cleared", 8'h55, 0, 0, 0);

      // flush by disable
      send(8'h66, 2'd3, 2'b00, 0, 1);
      send(8'h77, 2'd3, 2'b00, 0, 1);
      rx_en = 0; @(negedge clk);
      check("R2 flush", rx_ready, 0);
      check("R2 flush flags", {err_frame, err_overrun, err_parity}, 0);
      rx_en = 1; @(negedge clk);
      send(8'h88, 2'd3, 2'b00, 0, 1);
      read_chk("R2 after flush", 8'h88, 0, 0, 0);

      // random frames
      for (int n = 0; n < 40; n++) begin
         logic [7:0] d;
         logic [1:0] sel, pm;
         logic flip, sok;
         d    = 8'($urandom);
         sel  = 2'($urandom);
         pm   = 2'($urandom);
         flip = 1'($urandom_range(0, 3) == 0);
         sok  = 1'($urandom_range(0, 4) != 0);
         send(d, sel, pm, flip, sok);
         read_chk("R6 R7 random", mask_d(d, sel), ~sok, 0, pm[1] & flip);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule